// File: doc/BRIEF.md
# Miss status holding register file

This block tracks the cache misses that are still outstanding, so a non-blocking cache can keep accepting accesses while memory is busy. It has a small number of entries, one per missing block. Each entry holds the block address, an issued-to-memory flag, a mask of the subblocks that have come back, the subblock data, and a short list of load and store targets that wait on the block. A new miss merges into the entry that already tracks its block, claims a free entry and sends one memory request, or stalls.

Memory returns one subblock per cycle on the return port. Any pending stores to that subblock are merged into it as it is written, and any waiting loads become eligible for forwarding. Loads leave on the forward port one per cycle. When every subblock of an entry is present and no load still waits on it, the whole block is offered on the fill port. The entry is released when the fill is accepted.

The miss, memory-request, forward and fill ports are valid/ready streams: a transfer happens on a cycle where both are high. Once a valid is raised, it and the fields it carries that identify the transfer stay put until ready is seen. The miss port stalls through miss_ready. The return port has no ready: the block takes a returned subblock on every cycle where ret_valid is high.

Top module: `mshr_file`

## Requirements
- R1: A miss whose block is not tracked, with a free entry available, is accepted into the lowest free entry. A memory request for that block address, carrying that entry number, is then offered. Requests are offered in entry order.
- R2: A miss to a block that an entry already tracks is accepted as a new target in that entry and causes no further memory request.
- R3: miss_ready is low when the block is not tracked and all entries are busy. It is also low when the block is tracked, the access needs a target slot, and all slots of that entry are taken.
- R4: mreq_valid, once high, stays high with the same mreq_id and mreq_addr until mreq_ready is seen.
- R5: After a subblock returns, each load waiting on it is forwarded exactly once, one per cycle, with the returned subblock word on fwd_data. The order is lowest entry first and, within an entry, lowest slot first. The subblock number is miss_off bits [3:2].
- R6: A load to a tracked block whose subblock has already arrived is forwarded from the entry without any new memory request or return.
- R7: A store writes its bytes into the subblock. miss_size 0, 1 and 2 select 1, 2 and 4 bytes, and the bytes start at lane miss_off[1:0], with lane b at bits [8b+7:8b]. A store to a missing subblock waits in a slot and is merged over the returned word. A store to a present subblock is written at once and takes no slot. Stores are never forwarded.
- R8: When all subblocks of an entry are present and no load waits on it, fill_valid offers the block address and data, with subblock s at fill_data bits [32s+31:32s]. The entry is freed on the fill handshake, and a later miss to that block allocates a new entry.
- R9: A miss to the block being offered on the fill port is stalled.
- R10: A prefetch miss allocates an entry and a request without taking a slot, so its block goes to the fill port with nothing forwarded. A prefetch to a tracked block is accepted and has no effect.
- R11: After reset, no entry is valid: miss_ready is high and mreq_valid, fwd_valid and fill_valid are low.
- R12: fwd_valid and fill_valid, once high, stay high with the same fwd_tag and fill_addr until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Miss accepted this cycle |
| miss_addr | input | AW | Block address of the miss |
| miss_store | input | 1 | Access is a store |
| miss_prefetch | input | 1 | Access is a prefetch (no target) |
| miss_size | input | 2 | log2 of access bytes |
| miss_off | input | OW | Byte offset in block |
| miss_tag | input | TW | Destination tag of the access |
| miss_wdata | input | SW | Store data, already in byte lanes |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory takes the request |
| mreq_addr | output | AW | Requested block address |
| mreq_id | output | EW | Entry number to quote on return |
| ret_valid | input | 1 | A subblock is returning |
| ret_id | input | EW | Entry the subblock belongs to |
| ret_sub | input | SIW | Subblock number |
| ret_data | input | SW | Subblock data |
| fwd_valid | output | 1 | Load forward valid |
| fwd_ready | input | 1 | Load unit takes the forward |
| fwd_tag | output | TW | Destination tag of the load |
| fwd_off | output | OW | Byte offset of the load |
| fwd_size | output | 2 | Size of the load |
| fwd_data | output | SW | Subblock word holding the load bytes |
| fill_valid | output | 1 | Completed block offered to the cache |
| fill_ready | input | 1 | Cache takes the block |
| fill_addr | output | AW | Block address |
| fill_data | output | NS*SW | Whole block |

## Verification
A lost or duplicated slot shows at the forward port within a few cycles of the matching return: a tag goes missing, comes out twice, or comes out of order. A wrong arrived mask or store merge shows up as a wrong word on fwd_data or in the fill data. An entry that is not freed, or is freed too early, shows on the next miss to that block as a wrong miss_ready or a missing memory request. The bench therefore checks forward order and data right after each return, the exact fill word, and the stall and request behaviour around the release.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // access size code: log2 of the byte count
  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;

  // slot kind
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/mshr_pick.sv
// Lowest-index pick; with HOLD set, an offered pick is frozen until taken.
module mshr_pick #(
  parameter int N    = 4,
  parameter bit HOLD = 1'b0,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] first;

  always_comb begin
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) first = IW'(i);
    end
  end

  generate
    if (HOLD) begin : g_hold
      logic          held;
      logic [IW-1:0] held_idx;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held     <= 1'b0;
          held_idx <= '0;
        end else begin
          held     <= any && !take;
          held_idx <= idx;
        end
      end
      assign any = held || (|req);
      assign idx = held ? held_idx : first;
    end else begin : g_comb
      logic unused_in;
      assign unused_in = ^{clk, rst_n, take};
      assign any = |req;
      assign idx = first;
    end
  endgenerate
endmodule

// File: rtl/mshr_lookup.sv
// Address compare of one request against every valid entry.
module mshr_lookup #(
  parameter int NE = 4,
  parameter int AW = 26
) (
  input  logic [NE-1:0] ent_v,
  input  logic [AW-1:0] ent_addr [NE],
  input  logic [AW-1:0] addr,
  output logic [NE-1:0] hit
);
  for (genvar e = 0; e < NE; e++) begin : g_cmp
    assign hit[e] = ent_v[e] && (ent_addr[e] == addr);
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int NE  = 4,   // entries
  parameter int NS  = 4,   // subblocks per block
  parameter int NSL = 4,   // target slots per entry
  parameter int SB  = 4,   // bytes per subblock
  parameter int AW  = 26,  // block address width
  parameter int TW  = 6,   // destination tag width
  localparam int SW  = 8 * SB,
  localparam int EW  = $clog2(NE),
  localparam int SIW = $clog2(NS),
  localparam int LW  = $clog2(SB),
  localparam int OW  = SIW + LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [AW-1:0]    miss_addr,
  input  logic             miss_store,
  input  logic             miss_prefetch,
  input  logic [1:0]       miss_size,
  input  logic [OW-1:0]    miss_off,
  input  logic [TW-1:0]    miss_tag,
  input  logic [SW-1:0]    miss_wdata,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic [AW-1:0]    mreq_addr,
  output logic [EW-1:0]    mreq_id,
  input  logic             ret_valid,
  input  logic [EW-1:0]    ret_id,
  input  logic [SIW-1:0]   ret_sub,
  input  logic [SW-1:0]    ret_data,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output logic [TW-1:0]    fwd_tag,
  output logic [OW-1:0]    fwd_off,
  output logic [1:0]       fwd_size,
  output logic [SW-1:0]    fwd_data,
  output logic             fill_valid,
  input  logic             fill_ready,
  output logic [AW-1:0]    fill_addr,
  output logic [NS*SW-1:0] fill_data
);
  localparam int SLW = $clog2(NSL);
  localparam int FW  = EW + SLW;

  typedef struct packed {
    acc_kind_e     kind;
    logic [1:0]    size;
    logic [OW-1:0] off;
    logic [TW-1:0] tag;
    logic [SW-1:0] wd;
  } slot_t;

  logic [NE-1:0]  ent_v, ent_iss, done;
  logic [AW-1:0]  ent_addr [NE];
  logic [NS-1:0]  ent_arr  [NE];
  logic [SW-1:0]  ent_data [NE][NS];
  logic [NSL-1:0] sl_v     [NE];
  slot_t          sl       [NE][NSL];

  function automatic logic [SB-1:0] lanes(input logic [1:0] size, input logic [OW-1:0] off);
    int lo, n;
    lo = int'(off[LW-1:0]);
    n  = 1 << size;
    for (int b = 0; b < SB; b++) lanes[b] = (b >= lo) && (b < lo + n);
  endfunction

  function automatic logic [SW-1:0] put_bytes(input logic [SW-1:0] old, input logic [SW-1:0] wd,
                                              input logic [SB-1:0] m);
    put_bytes = old;
    for (int b = 0; b < SB; b++) if (m[b]) put_bytes[b*8 +: 8] = wd[b*8 +: 8];
  endfunction

  // lookup and allocation picks
  logic [NE-1:0]  hit_vec;
  logic           hit_any, free_any, sfree_any;
  logic [EW-1:0]  hit_idx, free_idx;
  logic [SLW-1:0] sfree_idx;
  logic [SIW-1:0] msub;

  mshr_lookup #(.NE(NE), .AW(AW)) u_look (
    .ent_v(ent_v), .ent_addr(ent_addr), .addr(miss_addr), .hit(hit_vec));
  mshr_pick #(.N(NE)) u_hit_pick (
    .clk(clk), .rst_n(rst_n), .req(hit_vec), .take(1'b0), .any(hit_any), .idx(hit_idx));
  mshr_pick #(.N(NE)) u_free_pick (
    .clk(clk), .rst_n(rst_n), .req(~ent_v), .take(1'b0), .any(free_any), .idx(free_idx));
  mshr_pick #(.N(NSL)) u_slot_pick (
    .clk(clk), .rst_n(rst_n), .req(~sl_v[hit_idx]), .take(1'b0), .any(sfree_any), .idx(sfree_idx));

  assign msub = miss_off[OW-1:LW];

  for (genvar e = 0; e < NE; e++) begin : g_done
    assign done[e] = ent_v[e] && (&ent_arr[e]) && !(|sl_v[e]);
  end

  logic ret_here, hit_arr_now, miss_fire, do_alloc, do_direct, do_slot;
  logic [EW-1:0]  s_ent;
  logic [SLW-1:0] s_slot;

  assign ret_here    = ret_valid && (ret_id == hit_idx) && (ret_sub == msub);
  assign hit_arr_now = ent_arr[hit_idx][msub] || ret_here;

  always_comb begin
    if (hit_any)
      miss_ready = !done[hit_idx] &&
                   (miss_prefetch || (miss_store && hit_arr_now) || sfree_any);
    else
      miss_ready = free_any;
  end

  assign miss_fire = miss_valid && miss_ready;
  assign do_alloc  = miss_fire && !hit_any;
  assign do_direct = miss_fire && hit_any && !miss_prefetch && miss_store && hit_arr_now;
  assign do_slot   = miss_fire && !miss_prefetch && !do_direct;
  assign s_ent     = hit_any ? hit_idx : free_idx;
  assign s_slot    = hit_any ? sfree_idx : '0;

  // returned word with waiting stores merged over it, in slot order
  logic [SW-1:0]  ret_word, direct_word;
  logic [NSL-1:0] ret_clr;
  always_comb begin
    ret_word = ret_data;
    ret_clr  = '0;
    for (int s = 0; s < NSL; s++) begin
      if (sl_v[ret_id][s] && sl[ret_id][s].kind == ACC_STORE &&
          sl[ret_id][s].off[OW-1:LW] == ret_sub) begin
        ret_word   = put_bytes(ret_word, sl[ret_id][s].wd,
                               lanes(sl[ret_id][s].size, sl[ret_id][s].off));
        ret_clr[s] = 1'b1;
      end
    end
    direct_word = put_bytes(ret_here ? ret_word : ent_data[hit_idx][msub], miss_wdata,
                            lanes(miss_size, miss_off));
  end

  // memory request, forward and fill arbiters (held once offered)
  logic [NE*NSL-1:0] fwd_req;
  logic [FW-1:0]     fwd_sel;
  logic [EW-1:0]     fe, fill_sel;
  logic [SLW-1:0]    fs;

  always_comb begin
    for (int e = 0; e < NE; e++)
      for (int s = 0; s < NSL; s++)
        fwd_req[e*NSL+s] = sl_v[e][s] && sl[e][s].kind == ACC_LOAD &&
                           ent_arr[e][sl[e][s].off[OW-1:LW]];
  end

  mshr_pick #(.N(NE), .HOLD(1'b1)) u_req_pick (
    .clk(clk), .rst_n(rst_n), .req(ent_v & ~ent_iss), .take(mreq_ready),
    .any(mreq_valid), .idx(mreq_id));
  mshr_pick #(.N(NE*NSL), .HOLD(1'b1), .IW(FW)) u_fwd_pick (
    .clk(clk), .rst_n(rst_n), .req(fwd_req), .take(fwd_ready),
    .any(fwd_valid), .idx(fwd_sel));
  mshr_pick #(.N(NE), .HOLD(1'b1)) u_fill_pick (
    .clk(clk), .rst_n(rst_n), .req(done), .take(fill_ready),
    .any(fill_valid), .idx(fill_sel));

  assign fe        = fwd_sel[FW-1:SLW];
  assign fs        = fwd_sel[SLW-1:0];
  assign mreq_addr = ent_addr[mreq_id];
  assign fwd_tag   = sl[fe][fs].tag;
  assign fwd_off   = sl[fe][fs].off;
  assign fwd_size  = sl[fe][fs].size;
  assign fwd_data  = ent_data[fe][sl[fe][fs].off[OW-1:LW]];
  assign fill_addr = ent_addr[fill_sel];

  always_comb begin
    for (int s = 0; s < NS; s++) fill_data[s*SW +: SW] = ent_data[fill_sel][s];
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v   <= '0;
      ent_iss <= '0;
      for (int e = 0; e < NE; e++) begin
        ent_arr[e] <= '0;
        sl_v[e]    <= '0;
      end
    end else begin
      if (mreq_valid && mreq_ready) ent_iss[mreq_id] <= 1'b1;
      if (fill_valid && fill_ready) ent_v[fill_sel] <= 1'b0;
      if (ret_valid) begin
        ent_arr[ret_id][ret_sub] <= 1'b1;
        sl_v[ret_id]             <= sl_v[ret_id] & ~ret_clr;
      end
      if (fwd_valid && fwd_ready) sl_v[fe][fs] <= 1'b0;
      if (do_alloc) begin
        ent_v[free_idx]   <= 1'b1;
        ent_iss[free_idx] <= 1'b0;
        ent_arr[free_idx] <= '0;
      end
      if (do_slot) sl_v[s_ent][s_slot] <= 1'b1;
    end
  end

  // payload state
  always_ff @(posedge clk) begin
    if (ret_valid) ent_data[ret_id][ret_sub] <= ret_word;
    if (do_direct) ent_data[hit_idx][msub] <= direct_word;
    if (do_alloc)  ent_addr[free_idx] <= miss_addr;
    if (do_slot)
      sl[s_ent][s_slot] <= '{kind: acc_kind_e'(miss_store), size: miss_size, off: miss_off,
                             tag: miss_tag, wd: miss_wdata};
  end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NE = 4,
  parameter int AW = 26,
  parameter int EW = 2,
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_valid,
  input logic          miss_ready,
  input logic [AW-1:0] miss_addr,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic [AW-1:0] mreq_addr,
  input logic [EW-1:0] mreq_id,
  input logic          fwd_valid,
  input logic          fwd_ready,
  input logic [TW-1:0] fwd_tag,
  input logic          fill_valid,
  input logic          fill_ready,
  input logic [AW-1:0] fill_addr,
  input logic [NE-1:0] ent_v,
  input logic [AW-1:0] ent_addr [NE]
);
  logic tracked;
  always_comb begin
    tracked = 1'b0;
    for (int e = 0; e < NE; e++) if (ent_v[e] && ent_addr[e] == miss_addr) tracked = 1'b1;
  end

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && (&ent_v) && !tracked) |-> !miss_ready);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_id) && $stable(mreq_addr)));

  // R9
  fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && miss_valid && miss_addr == fill_addr) |-> !miss_ready);

  // R12
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_tag)));

  // R12
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr)));
endmodule

bind mshr_file mshr_file_chk #(.NE(NE), .AW(AW), .EW(EW), .TW(TW)) u_chk (.*);

// File: tb/mshr_file_bench.sv
module mshr_file_bench;
  localparam int PERIOD = 10;
  localparam logic [25:0] A = 26'h100, B = 26'h200, C = 26'h300, D = 26'h400, E = 26'h500;

  typedef struct packed {
    logic [25:0] addr;
    logic        st;
    logic        pf;
    logic [1:0]  sz;
    logic [3:0]  off;
    logic [5:0]  tag;
    logic [31:0] wd;
    logic        rdy;
  } vec_t;

  // R1 allocations, R2 merges, R3 stalls, R10 prefetch
  localparam vec_t VECS [10] = '{
    '{A, 1'b0, 1'b0, 2'd2, 4'd0,  6'd1, 32'h0,        1'b1},
    '{A, 1'b0, 1'b0, 2'd2, 4'd4,  6'd2, 32'h0,        1'b1},
    '{A, 1'b1, 1'b0, 2'd0, 4'd9,  6'd3, 32'h0000EE00, 1'b1},
    '{A, 1'b0, 1'b0, 2'd2, 4'd0,  6'd4, 32'h0,        1'b1},
    '{A, 1'b0, 1'b0, 2'd2, 4'd4,  6'd5, 32'h0,        1'b0},
    '{B, 1'b0, 1'b0, 2'd2, 4'd0,  6'd6, 32'h0,        1'b1},
    '{C, 1'b0, 1'b1, 2'd2, 4'd0,  6'd0, 32'h0,        1'b1},
    '{D, 1'b0, 1'b0, 2'd2, 4'd12, 6'd7, 32'h0,        1'b1},
    '{E, 1'b0, 1'b0, 2'd2, 4'd0,  6'd8, 32'h0,        1'b0},
    '{B, 1'b0, 1'b1, 2'd2, 4'd0,  6'd0, 32'h0,        1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, miss_ready, miss_store = 1'b0, miss_prefetch = 1'b0;
  logic [25:0] miss_addr = '0, mreq_addr, fill_addr;
  logic [1:0] miss_size = '0, fwd_size;
  logic [3:0] miss_off = '0, fwd_off;
  logic [5:0] miss_tag = '0, fwd_tag;
  logic [31:0] miss_wdata = '0, ret_data = '0, fwd_data;
  logic mreq_valid, mreq_ready = 1'b0, ret_valid = 1'b0, fwd_valid, fwd_ready = 1'b0;
  logic fill_valid, fill_ready = 1'b0;
  logic [1:0] mreq_id, ret_id = '0, ret_sub = '0;
  logic [127:0] fill_data;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mshr_file u_mshr_file (.*);

  function automatic logic [31:0] mem_word(input logic [25:0] a, input int s);
    return {a[15:0], 8'(s), 8'h5A};
  endfunction

  task automatic chk(input logic ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic send_miss(input vec_t v, input string rq);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = v.addr; miss_store = v.st; miss_prefetch = v.pf;
    miss_size = v.sz; miss_off = v.off; miss_tag = v.tag; miss_wdata = v.wd;
    #1 chk(miss_ready == v.rdy, rq, 128'(miss_ready), 128'(v.rdy));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic send_ret(input logic [1:0] id, input logic [1:0] sub, input logic [31:0] d);
    @(negedge clk);
    ret_valid = 1'b1; ret_id = id; ret_sub = sub; ret_data = d;
    @(negedge clk);
    ret_valid = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [25:0] req_order [4];
    logic [127:0] exp_blk;
    req_order = '{A, B, C, D};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(miss_ready, "R11 miss_ready", 128'(miss_ready), 128'(1));
    chk(!mreq_valid && !fwd_valid && !fill_valid, "R11 valids",
        128'({mreq_valid, fwd_valid, fill_valid}), 128'(0));

    for (int i = 0; i < 10; i++) send_miss(VECS[i], $sformatf("R1/R2/R3/R10 row %0d", i));

    #1 chk(mreq_valid && mreq_addr == A, "R1 first request", 128'(mreq_addr), 128'(A));
    repeat (2) @(negedge clk);
    #1 chk(mreq_valid && mreq_id == 2'd0, "R4 request held", 128'(mreq_id), 128'(0));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mreq_ready = 1'b1;
      #1 chk(mreq_valid && mreq_addr == req_order[k] && mreq_id == 2'(k), "R1 request order",
             128'(mreq_addr), 128'(req_order[k]));
    end
    @(negedge clk);
    mreq_ready = 1'b0;
    #1 chk(!mreq_valid, "R2 no request for merges", 128'(mreq_valid), 128'(0));

    fwd_ready = 1'b1;
    send_ret(2'd0, 2'd0, mem_word(A, 0));
    chk(fwd_valid && fwd_tag == 6'd1 && fwd_data == mem_word(A, 0), "R5 first load",
        128'({fwd_tag, fwd_data}), 128'({6'd1, mem_word(A, 0)}));
    @(negedge clk);
    #1 chk(fwd_valid && fwd_tag == 6'd4, "R5 second load in slot order", 128'(fwd_tag), 128'(4));
    @(negedge clk);
    #1 chk(!fwd_valid, "R5 each load once", 128'(fwd_valid), 128'(0));

    send_ret(2'd0, 2'd2, mem_word(A, 2));
    chk(!fwd_valid, "R7 store not forwarded", 128'(fwd_valid), 128'(0));

    send_miss('{A, 1'b0, 1'b0, 2'd2, 4'd8, 6'd8, 32'h0, 1'b1}, "R6 late load accepted");
    #1 chk(fwd_valid && fwd_tag == 6'd8 && fwd_data == 32'h0100EE5A, "R6 R7 direct forward merged",
           128'({fwd_tag, fwd_data}), 128'({6'd8, 32'h0100EE5A}));
    chk(!mreq_valid, "R6 no request", 128'(mreq_valid), 128'(0));
    @(negedge clk);

    send_miss('{A, 1'b1, 1'b0, 2'd1, 4'd2, 6'd9, 32'hCAFE0000, 1'b1}, "R7 direct store accepted");
    send_ret(2'd0, 2'd1, mem_word(A, 1));
    chk(fwd_valid && fwd_tag == 6'd2 && fwd_data == mem_word(A, 1), "R5 load on subblock 1",
        128'({fwd_tag, fwd_data}), 128'({6'd2, mem_word(A, 1)}));
    @(negedge clk);

    send_ret(2'd0, 2'd3, mem_word(A, 3));
    exp_blk = {mem_word(A, 3), 32'h0100EE5A, mem_word(A, 1), 32'hCAFE005A};
    chk(fill_valid && fill_addr == A, "R8 fill offered", 128'(fill_addr), 128'(A));
    chk(fill_data == exp_blk, "R7 R8 fill data", fill_data, exp_blk);

    send_miss('{A, 1'b0, 1'b0, 2'd2, 4'd0, 6'd10, 32'h0, 1'b0}, "R9 stall during fill");
    #1 chk(fill_valid && fill_addr == A, "R12 fill held", 128'(fill_addr), 128'(A));
    @(negedge clk);
    fill_ready = 1'b1;
    @(negedge clk);
    fill_ready = 1'b0;
    #1 chk(!fill_valid, "R8 entry released", 128'(fill_valid), 128'(0));

    send_miss('{A, 1'b0, 1'b0, 2'd2, 4'd0, 6'd11, 32'h0, 1'b1}, "R8 reallocation");
    #1 chk(mreq_valid && mreq_addr == A && mreq_id == 2'd0, "R8 new request",
           128'({mreq_id, mreq_addr}), 128'({2'd0, A}));

    for (int s = 0; s < 4; s++) send_ret(2'd2, 2'(s), mem_word(C, s));
    exp_blk = {mem_word(C, 3), mem_word(C, 2), mem_word(C, 1), mem_word(C, 0)};
    chk(fill_valid && fill_addr == C && fill_data == exp_blk, "R10 prefetch fill",
        fill_data, exp_blk);
    chk(!fwd_valid, "R10 nothing forwarded", 128'(fwd_valid), 128'(0));
    fill_ready = 1'b1;
    @(negedge clk);
    fill_ready = 1'b0;

    finished = 1'b1;
    summary();
  end
endmodule